// File: doc/BRIEF.md
# Integer Overflow Flag Generator

This block sits beside the fixed-point datapath of an execution unit. For each operation it receives the operation code, the left operand, the right operand and the result the datapath already computed. It does not do the arithmetic. From those values it decides whether the operation overflowed and registers that decision as a one-bit overflow flag. A second flag, the summary, gathers every overflow until software or reset clears it.

A mode input picks 64-bit or 32-bit operation. In 32-bit mode only the low half of each operand and of the result is used. The flags change only on a clock edge where the update enable is high and the operation code is legal. An update with an unknown code raises an illegal-operation output and leaves both flags as they were.

Top module: `ovf_flag_gen`

## Requirements
- R1: While reset is low, and on the first cycle after it, `ovFlag` and `sumFlag` read 0.
- R2: Codes 0 (add) and 1 (add-extended): overflow is 1 exactly when the top bits of left and right are equal and the top bit of the result differs from the top bit of left.
- R3: Codes 6, 7 and 8 (the subtract-from family, result = right − left): the R2 test is applied with the bitwise inverse of left in place of left.
- R4: Code 2 (signed divide, left ÷ right): overflow is 1 when right is zero, or when left is the most negative value and right is all ones.
- R5: Code 3 (unsigned divide): overflow is 1 exactly when right is zero.
- R6: Code 4 (low-word multiply): in 64-bit mode overflow is 1 when result bits 63:32 are not all copies of result bit 31. In 32-bit mode the overflow is always 0.
- R7: Code 5 (negate): overflow is 1 exactly when left is the most negative value.
- R8: With `mode64` = 0, only bits 31:0 of left, right and result are used. The top bit is bit 31 and the most negative value is 0x80000000. With `mode64` = 1 the top bit is bit 63.
- R9: A legal update with `updEn` = 1 loads the overflow decision into `ovFlag` at the clock edge. It is visible in the next cycle. With `updEn` = 0 both flags hold.
- R10: On each legal update `sumFlag` becomes its old value OR the new overflow decision. Once set, it stays 1 until it is cleared.
- R11: `clrSum` = 1 clears `sumFlag` at the next edge. This wins over a summary set by an update in the same cycle. `ovFlag` still takes that update.
- R12: `illegalOp` is high, in the same cycle and with no register in the path, whenever `updEn` = 1 and `opCode` is 9 to 15. Such an update leaves both flags unchanged. With `updEn` = 0, `illegalOp` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| updEn | input | 1 | Flag update enable for this cycle's operation |
| clrSum | input | 1 | Clear request for the summary flag |
| mode64 | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| opCode | input | 4 | Operation code, 0 to 8 legal |
| opLeft | input | 64 | Left operand |
| opRight | input | 64 | Right operand |
| opResult | input | 64 | Result produced by the datapath |
| ovFlag | output | 1 | Registered overflow flag of the last legal update |
| sumFlag | output | 1 | Sticky summary overflow flag |
| illegalOp | output | 1 | Update attempted with an unknown operation code |

## Verification
The sign-rule classes are driven with three kinds of operand pairs: same-sign pairs whose result wraps, same-sign pairs that do not wrap, and mixed-sign pairs whose result sign would look like a wrap. Only the rule itself tells these three apart.

Divide and negate are tried on the most negative value, on all-ones and on zero operands. They are also tried on neighbours of those values, so that an exact comparison can be told from a partial one.

The 32-bit cases set the upper half of the inputs against the answer: garbage there would flip the decision if the mode were ignored.

Directed sequences then separate three behaviours: holding when the enable is low, clear-versus-set priority on the summary, and rejection of illegal codes.

// File: rtl/ovf_pkg.sv
`timescale 1ns/1ps
package ovf_pkg;

  typedef enum logic [2:0] {
    CLS_NONE = 3'd0,
    CLS_ADD  = 3'd1,
    CLS_SUB  = 3'd2,
    CLS_DIVS = 3'd3,
    CLS_DIVU = 3'd4,
    CLS_MUL  = 3'd5,
    CLS_NEG  = 3'd6
  } ovClass_e;

  typedef struct packed {
    logic     load;
    logic     clear;
    ovClass_e cls;
  } ovStrobe_t;

endpackage

// File: rtl/ovf_ctrl.sv
`timescale 1ns/1ps
module ovf_ctrl
  import ovf_pkg::*;
#(
  parameter int OPC_W   = 4,
  parameter int OPC_MAX = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             updEn,
  input  logic             clrSum,
  input  logic [OPC_W-1:0] opCode,
  output ovStrobe_t        stb,
  output logic             illegalOp
);

  localparam logic [OPC_W-1:0] LAST_CODE = OPC_W'(OPC_MAX);

  ovClass_e decCls;
  logic     codeOk;

  always_comb begin
    unique case (opCode)
      OPC_W'(0), OPC_W'(1):             decCls = CLS_ADD;
      OPC_W'(2):                        decCls = CLS_DIVS;
      OPC_W'(3):                        decCls = CLS_DIVU;
      OPC_W'(4):                        decCls = CLS_MUL;
      OPC_W'(5):                        decCls = CLS_NEG;
      OPC_W'(6), OPC_W'(7), OPC_W'(8): decCls = CLS_SUB;
      default:                          decCls = CLS_NONE;
    endcase
  end

  assign codeOk    = (opCode <= LAST_CODE);
  assign illegalOp = updEn && !codeOk;

  assign stb.load  = updEn && codeOk;
  assign stb.clear = clrSum;
  assign stb.cls   = decCls;

  AST_ILLEGAL_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> !stb.load) else $error("illegal code produced a load"); // R12

  AST_LOAD_HAS_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |-> (stb.cls != CLS_NONE)) else $error("load without class"); // R9

endmodule

// File: rtl/ovf_datapath.sv
`timescale 1ns/1ps
module ovf_datapath
  import ovf_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mode64,
  input  ovStrobe_t         stb,
  input  logic [DATA_W-1:0] opLeft,
  input  logic [DATA_W-1:0] opRight,
  input  logic [DATA_W-1:0] opResult,
  output logic              ovFlag,
  output logic              sumFlag
);

  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] MIN_FULL = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [HALF_W-1:0] MIN_HALF = {1'b1, {(HALF_W-1){1'b0}}};

  // width-selected views of the inputs
  logic msbL, msbR, msbRes;
  logic rZero, rOnes, lMinNeg;
  logic mulWide;
  logic newOv;

  always_comb begin
    if (mode64) begin
      msbL    = opLeft[DATA_W-1];
      msbR    = opRight[DATA_W-1];
      msbRes  = opResult[DATA_W-1];
      rZero   = (opRight == '0);
      rOnes   = (opRight == '1);
      lMinNeg = (opLeft == MIN_FULL);
      mulWide = (opResult[DATA_W-1:HALF_W] != {HALF_W{opResult[HALF_W-1]}});
    end else begin
      msbL    = opLeft[HALF_W-1];
      msbR    = opRight[HALF_W-1];
      msbRes  = opResult[HALF_W-1];
      rZero   = (opRight[HALF_W-1:0] == '0);
      rOnes   = (opRight[HALF_W-1:0] == '1);
      lMinNeg = (opLeft[HALF_W-1:0] == MIN_HALF);
      mulWide = 1'b0;
    end
  end

  logic addOv, subOv;
  assign addOv = (msbL == msbR) && (msbRes != msbL);
  assign subOv = (~msbL == msbR) && (msbRes != ~msbL);

  always_comb begin
    unique case (stb.cls)
      CLS_ADD:  newOv = addOv;
      CLS_SUB:  newOv = subOv;
      CLS_DIVS: newOv = rZero || (lMinNeg && rOnes);
      CLS_DIVU: newOv = rZero;
      CLS_MUL:  newOv = mulWide;
      CLS_NEG:  newOv = lMinNeg;
      default:  newOv = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovFlag <= 1'b0;
    end else if (stb.load) begin
      ovFlag <= newOv;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumFlag <= 1'b0;
    end else if (stb.clear) begin
      sumFlag <= 1'b0;
    end else if (stb.load) begin
      sumFlag <= sumFlag | newOv;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> $stable(ovFlag)) else $error("ovFlag moved without load"); // R9

  AST_SUM_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (sumFlag && !stb.clear) |=> sumFlag) else $error("summary dropped"); // R10

  AST_SUM_ACCUM: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && !stb.clear) |=> (sumFlag == ($past(sumFlag) | ovFlag)))
    else $error("summary not OR of old and new"); // R10

  AST_SUM_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> !sumFlag) else $error("summary survived clear"); // R11

  AST_DIVU_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.cls == CLS_DIVU && rZero) |=> ovFlag)
    else $error("divide by zero missed"); // R5

  AST_NEG_MIN: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.cls == CLS_NEG) |=> (ovFlag == $past(lMinNeg)))
    else $error("negate overflow wrong"); // R7

endmodule

// File: rtl/ovf_flag_gen.sv
`timescale 1ns/1ps
module ovf_flag_gen
  import ovf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int OPC_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              updEn,
  input  logic              clrSum,
  input  logic              mode64,
  input  logic [OPC_W-1:0]  opCode,
  input  logic [DATA_W-1:0] opLeft,
  input  logic [DATA_W-1:0] opRight,
  input  logic [DATA_W-1:0] opResult,
  output logic              ovFlag,
  output logic              sumFlag,
  output logic              illegalOp
);

  ovStrobe_t stb;

  ovf_ctrl #(.OPC_W(OPC_W), .OPC_MAX(8)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .updEn     (updEn),
    .clrSum    (clrSum),
    .opCode    (opCode),
    .stb       (stb),
    .illegalOp (illegalOp)
  );

  ovf_datapath #(.DATA_W(DATA_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .mode64   (mode64),
    .stb      (stb),
    .opLeft   (opLeft),
    .opRight  (opRight),
    .opResult (opResult),
    .ovFlag   (ovFlag),
    .sumFlag  (sumFlag)
  );

endmodule

// File: tb/ovf_flag_gen_test.sv
`timescale 1ns/1ps
module ovf_flag_gen_test;

  typedef struct packed {
    logic        m64;
    logic [3:0]  opc;
    logic [63:0] l;
    logic [63:0] r;
    logic [63:0] res;
    logic        exp;
  } vec_t;

  localparam int NV = 26;
  localparam logic [63:0] MN = 64'h8000_0000_0000_0000;
  localparam logic [63:0] MX = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] AO = 64'hFFFF_FFFF_FFFF_FFFF;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'd0, MX, 64'd1, MN, 1'b1},                       // R2 wrap positive
    '{1'b1, 4'd0, 64'd1, 64'd2, 64'd3, 1'b0},                 // R2 no wrap
    '{1'b1, 4'd1, MN, MN, 64'd0, 1'b1},                       // R2 wrap negative
    '{1'b1, 4'd0, AO, 64'd1, 64'd0, 1'b0},                    // R2 mixed signs
    '{1'b1, 4'd6, 64'd1, MN, MX, 1'b1},                       // R3 min minus one
    '{1'b1, 4'd7, 64'd5, 64'd10, 64'd5, 1'b0},                // R3 plain
    '{1'b1, 4'd8, MN, 64'd0, MN, 1'b1},                       // R3 zero minus min
    '{1'b1, 4'd2, MN, AO, 64'd0, 1'b1},                       // R4 min / -1
    '{1'b1, 4'd2, 64'd10, 64'd0, 64'd0, 1'b1},                // R4 by zero
    '{1'b1, 4'd2, 64'd10, 64'd2, 64'd5, 1'b0},                // R4 plain
    '{1'b1, 4'd2, MN, 64'd1, MN, 1'b0},                       // R4 min / 1
    '{1'b1, 4'd3, MN, AO, 64'd0, 1'b0},                       // R5 no signed case
    '{1'b1, 4'd3, 64'd7, 64'd0, 64'd0, 1'b1},                 // R5 by zero
    '{1'b1, 4'd4, 64'd0, 64'd0, 64'h0000_0000_8000_0000, 1'b1}, // R6 upper mismatch
    '{1'b1, 4'd4, 64'd0, 64'd0, 64'hFFFF_FFFF_8000_0000, 1'b0}, // R6 sign ext ok
    '{1'b1, 4'd4, 64'd0, 64'd0, 64'h0000_0000_7FFF_FFFF, 1'b0}, // R6 positive ok
    '{1'b1, 4'd5, MN, 64'd0, MN, 1'b1},                       // R7 min
    '{1'b1, 4'd5, 64'd1, 64'd0, AO, 1'b0},                    // R7 plain
    '{1'b0, 4'd0, 64'h7FFF_FFFF, 64'd1, 64'h8000_0000, 1'b1},  // R8 add wrap low half
    '{1'b0, 4'd0, MX, 64'd1, MN, 1'b0},                       // R8 upper half ignored
    '{1'b0, 4'd5, 64'hFFFF_FFFF_8000_0000, 64'd0, 64'd0, 1'b1}, // R8 negate min32
    '{1'b0, 4'd5, MN, 64'd0, 64'd0, 1'b0},                    // R8 negate min64 low 0
    '{1'b0, 4'd2, 64'h8000_0000, 64'hFFFF_FFFF, 64'd0, 1'b1},  // R8 divs min32/-1
    '{1'b0, 4'd3, 64'd9, 64'hFFFF_FFFF_0000_0000, 64'd0, 1'b1}, // R8 divu low zero
    '{1'b0, 4'd4, 64'd0, 64'd0, 64'h0000_0000_8000_0000, 1'b0}, // R6 32-bit never
    '{1'b0, 4'd6, 64'd1, 64'h8000_0000, 64'h7FFF_FFFF, 1'b1}   // R8 subtract-from
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        updEn = 1'b0;
  logic        clrSum = 1'b0;
  logic        mode64 = 1'b1;
  logic [3:0]  opCode = '0;
  logic [63:0] opLeft = '0;
  logic [63:0] opRight = '0;
  logic [63:0] opResult = '0;
  logic        ovFlag, sumFlag, illegalOp;

  int total = 0;
  int bad = 0;
  logic sumModel;

  always #2 clk = ~clk;

  ovf_flag_gen uut (
    .clk(clk), .rstN(rstN), .updEn(updEn), .clrSum(clrSum), .mode64(mode64),
    .opCode(opCode), .opLeft(opLeft), .opRight(opRight), .opResult(opResult),
    .ovFlag(ovFlag), .sumFlag(sumFlag), .illegalOp(illegalOp)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  function automatic string reqOf(input logic m64, input logic [3:0] opc);
    string s;
    case (opc)
      4'd0, 4'd1:       s = "R2";
      4'd2:             s = "R4";
      4'd3:             s = "R5";
      4'd4:             s = "R6";
      4'd5:             s = "R7";
      default:          s = "R3";
    endcase
    if (!m64) s = {s, "/R8"};
    return s;
  endfunction

  task automatic drive(input logic m64, input logic [3:0] opc, input logic [63:0] l,
                       input logic [63:0] r, input logic [63:0] res, input logic en,
                       input logic clr);
    mode64 = m64; opCode = opc; opLeft = l; opRight = r; opResult = res;
    updEn = en; clrSum = clr;
  endtask

  task automatic idle();
    updEn = 1'b0; clrSum = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1", "ovFlag in reset", ovFlag, 1'b0);
    chk("R1", "sumFlag in reset", sumFlag, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "ovFlag after reset", ovFlag, 1'b0);
    chk("R1", "sumFlag after reset", sumFlag, 1'b0);
    chk("R12", "illegalOp idle", illegalOp, 1'b0);

    // vector table
    sumModel = 1'b0;
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].m64, VECS[i].opc, VECS[i].l, VECS[i].r, VECS[i].res, 1'b1, 1'b0);
      @(negedge clk);
      idle();
      chk(reqOf(VECS[i].m64, VECS[i].opc), "ovFlag", ovFlag, VECS[i].exp);
      sumModel = sumModel | VECS[i].exp;
      chk("R10", "sumFlag accumulate", sumFlag, sumModel);
    end

    // R11 clear alone, ovFlag kept (last vector left it at 1)
    clrSum = 1'b1;
    @(negedge clk);
    idle();
    chk("R11", "sumFlag cleared", sumFlag, 1'b0);
    chk("R9", "ovFlag kept over clear", ovFlag, 1'b1);

    // R9 hold: non-overflowing inputs with updEn low
    drive(1'b1, 4'd0, 64'd1, 64'd1, 64'd2, 1'b0, 1'b0);
    @(negedge clk);
    chk("R9", "ovFlag held", ovFlag, 1'b1);
    chk("R9", "sumFlag held", sumFlag, 1'b0);

    // R10 no overflow, then overflow, then no overflow
    drive(1'b1, 4'd0, 64'd1, 64'd1, 64'd2, 1'b1, 1'b0);
    @(negedge clk);
    chk("R9", "ovFlag cleared by update", ovFlag, 1'b0);
    chk("R10", "sumFlag stays 0", sumFlag, 1'b0);
    drive(1'b1, 4'd3, 64'd1, 64'd0, 64'd0, 1'b1, 1'b0);
    @(negedge clk);
    chk("R10", "sumFlag set", sumFlag, 1'b1);
    drive(1'b1, 4'd3, 64'd4, 64'd2, 64'd2, 1'b1, 1'b0);
    @(negedge clk);
    idle();
    chk("R10", "ovFlag low again", ovFlag, 1'b0);
    chk("R10", "sumFlag sticky", sumFlag, 1'b1);

    // R11 clear together with overflowing update
    drive(1'b1, 4'd5, MN, 64'd0, MN, 1'b1, 1'b1);
    @(negedge clk);
    idle();
    chk("R11", "clear wins over set", sumFlag, 1'b0);
    chk("R11", "ovFlag still updated", ovFlag, 1'b1);

    // R12 illegal codes
    drive(1'b1, 4'd9, 64'd1, 64'd0, 64'd2, 1'b1, 1'b0);
    #1;
    chk("R12", "illegalOp code 9", illegalOp, 1'b1);
    @(negedge clk);
    chk("R12", "ovFlag unchanged", ovFlag, 1'b1);
    chk("R12", "sumFlag unchanged", sumFlag, 1'b0);
    drive(1'b1, 4'd15, 64'd1, 64'd0, 64'd2, 1'b1, 1'b0);
    #1;
    chk("R12", "illegalOp code 15", illegalOp, 1'b1);
    @(negedge clk);
    idle();
    chk("R12", "sumFlag unchanged 15", sumFlag, 1'b0);
    opCode = 4'd12;
    #1;
    chk("R12", "illegalOp without enable", illegalOp, 1'b0);
    opCode = 4'd8;
    updEn = 1'b1;
    #1;
    chk("R12", "illegalOp on code 8", illegalOp, 1'b0);
    @(negedge clk);
    idle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule